// File: doc/BRIEF.md
# Mailbox Transmit Inbox with Delivery Tracking

This block is the sending half of an inter-processor mailbox. A local processor composes a 64-bit message through a simple 32-bit register bus. It writes the two payload words and a target number, then writes a trigger. The message is posted into a one-entry slot held for that target, and the slot raises its valid line on a fetch port. The target takes the message by pulsing its acknowledge line.

For each of the eight targets the block keeps three flags in one status word. A busy flag stays set while a posted message is waiting. An overflow flag records a post that was refused because the slot was still busy. A delivered flag records that the target has fetched its message. Software learns that a transmission is complete when the busy flag has cleared. It clears overflow and delivered flags selectively through a clear register. Three interrupt sources (any busy, any overflow, any delivered), each with its own mask bit, are latched into one pending bit that drives the interrupt line.

Top module: `mbox_sender`

## Requirements
- R1: After reset all busy, overflow and delivered flags are 0, every fetch_valid bit is 0, the interrupt mask register (0x1C) reads 3'b111 and irq is 0.
- R2: Writing a value with bit 0 set to the trigger register 0x0C posts a message to the target held in bits 2:0 of register 0x00. The low word comes from 0x04 and the high word from 0x08. From the next cycle fetch_valid[t] is 1, slot t of fetch_data equals {high, low}, and status bit t is 1. A trigger write with bit 0 clear has no effect.
- R3: A post to a target whose busy flag is set sets status bit 8+t and discards the new message; the waiting message is unchanged.
- R4: fetch_ack[t] while fetch_valid[t] is 1 clears status bit t and sets delivered status bit 16+t on the next cycle; fetch_ack[t] while fetch_valid[t] is 0 is ignored.
- R5: A write to the clear register 0x10 clears exactly the overflow flags (bits 15:8) and delivered flags (bits 23:16) set in the written value. Busy flags are unaffected. A new event in the same cycle wins over the clear.
- R6: Mask register 0x1C bit 0 masks the any-busy source, bit 1 the any-overflow source and bit 2 the any-delivered source (1 = masked). The pending bit (0x18 bit 0, the irq output) sets one cycle after an unmasked source is active.
- R7: Writing 1 to bit 0 of 0x18 clears the pending bit. If an unmasked source is still active, the bit sets again on the following cycle.
- R8: The eight targets are independent: each has its own slot, flags and fetch port, and several may be posted and acknowledged together.
- R9: The status register 0x14 reads {8'b0, delivered[7:0], overflow[7:0], busy[7:0]}. Registers 0x00, 0x04 and 0x08 read back their last written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fetch_valid | output | 8 | Per-target message waiting |
| fetch_data | output | 512 | Per-target 64-bit message, target t at bits 64t+63:64t |
| fetch_ack | input | 8 | Per-target fetch acknowledge |
| irq | output | 1 | Latched interrupt pending |

## Verification
The assertions take a few things for granted. A target may raise fetch_ack in any cycle, with or without a waiting message. Bus writes are single-cycle strobes whose address is stable while the strobe is high. The bench drives every input on the falling clock edge and holds each write for exactly one cycle. It raises acknowledges both alone and for several targets together, and also against idle slots. This exercises the ignore case without breaking those assumptions.

// File: rtl/mbox_sender_pkg.sv
// Package: shared sizes and register offsets of the mailbox transmit inbox.
// Assumes a byte-addressed register space of 8 address bits.
package mbox_sender_pkg;
    localparam int NUM_TGT = 8;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int TGT_W   = $clog2(NUM_TGT);
    localparam int MSG_W   = 2 * WORD_W;

    localparam logic [ADDR_W-1:0] OFS_TGT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LOW   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_HIGH  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_GO    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h1C;

    // interrupt mask bit positions; order is decoded by software
    localparam int MSK_BUSY = 0;
    localparam int MSK_OVF  = 1;
    localparam int MSK_DLV  = 2;
endpackage

// File: rtl/mbox_sender_slot.sv
// Module: one target's message slot with busy, overflow and delivered flags.
// Assumes post is a one-cycle pulse; ack is honoured only while busy.
module mbox_sender_slot #(
    parameter int MSG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post,
    input  logic [MSG_W-1:0] msg_in,
    input  logic             ack,
    input  logic             clr_ovf,
    input  logic             clr_dlv,
    output logic             busy,
    output logic             ovf,
    output logic             dlv,
    output logic [MSG_W-1:0] msg_out
);
    logic take;
    assign take = ack && busy;

    // busy flag and payload: load on accepted post, release on fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            msg_out <= '0;
        end else if (take) begin
            busy <= 1'b0;
        end else if (post && !busy) begin
            busy    <= 1'b1;
            msg_out <= msg_in;
        end
    end

    // overflow flag: refused post sets it, clear request drops it
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (post && busy)   ovf <= 1'b1;
        else if (clr_ovf)        ovf <= 1'b0;
    end

    // delivered flag: fetch sets it, clear request drops it
    always_ff @(posedge clk) begin
        if (!rst_n)       dlv <= 1'b0;
        else if (take)    dlv <= 1'b1;
        else if (clr_dlv) dlv <= 1'b0;
    end

    assert_post_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (post && !busy && !ack) |=> (busy && msg_out == $past(msg_in)));
    assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (post && busy) |=> (ovf && $stable(msg_out)));
    assert_fetch_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && busy) |=> (dlv && !busy));
    assert_idle_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !busy && !post && !clr_dlv) |=> ($stable(dlv) && !busy));
endmodule

// File: rtl/mbox_sender_irq.sv
// Module: combines masked flag sources into one latched pending bit.
// Assumes clr is a one-cycle pulse from a write-one to the pending register.
module mbox_sender_irq #(
    parameter int NUM_TGT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TGT-1:0] busy,
    input  logic [NUM_TGT-1:0] ovf,
    input  logic [NUM_TGT-1:0] dlv,
    input  logic [2:0]         mask,
    input  logic               clr,
    output logic               pend
);
    import mbox_sender_pkg::*;
    logic src;

    // one combined source from the three unmasked summary terms
    always_comb begin
        src = ((|busy) && !mask[MSK_BUSY]) ||
              ((|ovf)  && !mask[MSK_OVF])  ||
              ((|dlv)  && !mask[MSK_DLV]);
    end

    // pending latch: active source sets, write-one clears
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= src || (pend && !clr);
    end

    assert_irq_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src |=> pend);
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !src) |=> !pend);
endmodule

// File: rtl/mbox_sender_regs.sv
// Module: register decode for message composition, flag clears and masks.
// Assumes single-cycle writes; reads are combinational from bus_addr.
module mbox_sender_regs #(
    parameter int NUM_TGT = 8,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [NUM_TGT-1:0]       busy,
    input  logic [NUM_TGT-1:0]       ovf,
    input  logic [NUM_TGT-1:0]       dlv,
    input  logic                     pend,
    output logic [NUM_TGT-1:0]       post_vec,
    output logic [2*WORD_W-1:0]      msg,
    output logic [NUM_TGT-1:0]       clr_ovf,
    output logic [NUM_TGT-1:0]       clr_dlv,
    output logic                     pend_clr,
    output logic [2:0]               mask
);
    import mbox_sender_pkg::*;
    localparam int TW = $clog2(NUM_TGT);

    logic [WORD_W-1:0] low_q, high_q;
    logic [TW-1:0]     tgt_q;
    logic              wr_go, wr_clr;

    assign wr_go  = bus_wr && (bus_addr == OFS_GO)  && bus_wdata[0];
    assign wr_clr = bus_wr && (bus_addr == OFS_CLR);
    assign pend_clr = bus_wr && (bus_addr == OFS_PEND) && bus_wdata[0];
    assign msg    = {high_q, low_q};

    // composition registers and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            tgt_q  <= '0;
            mask   <= 3'b111;
        end else if (bus_wr) begin
            if (bus_addr == OFS_LOW)  low_q  <= bus_wdata;
            if (bus_addr == OFS_HIGH) high_q <= bus_wdata;
            if (bus_addr == OFS_TGT)  tgt_q  <= bus_wdata[TW-1:0];
            if (bus_addr == OFS_MASK) mask   <= bus_wdata[2:0];
        end
    end

    // one-hot post and per-target clear strobes
    always_comb begin
        for (int i = 0; i < NUM_TGT; i++) begin
            post_vec[i] = wr_go && (tgt_q == TW'(i));
            clr_ovf[i]  = wr_clr && bus_wdata[NUM_TGT + i];
            clr_dlv[i]  = wr_clr && bus_wdata[2*NUM_TGT + i];
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TGT:  bus_rdata[TW-1:0] = tgt_q;
            OFS_LOW:  bus_rdata = low_q;
            OFS_HIGH: bus_rdata = high_q;
            OFS_STAT: bus_rdata[3*NUM_TGT-1:0] = {dlv, ovf, busy};
            OFS_PEND: bus_rdata[0] = pend;
            OFS_MASK: bus_rdata[2:0] = mask;
            default:  bus_rdata = '0;
        endcase
    end

    assert_single_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(post_vec));
endmodule

// File: rtl/mbox_sender.sv
// Module: transmit inbox of an inter-processor mailbox, eight targets.
// Assumes one register master; each target fetches through valid/ack.
module mbox_sender #(
    parameter int NUM_TGT = mbox_sender_pkg::NUM_TGT,
    parameter int WORD_W  = mbox_sender_pkg::WORD_W,
    parameter int ADDR_W  = mbox_sender_pkg::ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic [NUM_TGT-1:0]          fetch_valid,
    output logic [NUM_TGT*2*WORD_W-1:0] fetch_data,
    input  logic [NUM_TGT-1:0]          fetch_ack,
    output logic                        irq
);
    localparam int MW = 2 * WORD_W;

    logic [NUM_TGT-1:0] busy, ovf, dlv, post_vec, clr_ovf, clr_dlv;
    logic [MW-1:0]      msg;
    logic               pend_clr;
    logic [2:0]         mask;

    mbox_sender_regs #(.NUM_TGT(NUM_TGT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .ovf(ovf),
        .dlv(dlv), .pend(irq), .post_vec(post_vec), .msg(msg),
        .clr_ovf(clr_ovf), .clr_dlv(clr_dlv), .pend_clr(pend_clr), .mask(mask)
    );

    // one slot per target
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
        mbox_sender_slot #(.MSG_W(MW)) u_slot (
            .clk(clk), .rst_n(rst_n), .post(post_vec[t]), .msg_in(msg),
            .ack(fetch_ack[t]), .clr_ovf(clr_ovf[t]), .clr_dlv(clr_dlv[t]),
            .busy(busy[t]), .ovf(ovf[t]), .dlv(dlv[t]),
            .msg_out(fetch_data[t*MW +: MW])
        );
    end

    assign fetch_valid = busy;

    mbox_sender_irq #(.NUM_TGT(NUM_TGT)) u_irq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ovf(ovf), .dlv(dlv),
        .mask(mask), .clr(pend_clr), .pend(irq)
    );

    assert_flags_cleared_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (busy == '0 && ovf == '0 && dlv == '0 && !irq));
endmodule

// File: tb/mbox_sender_bench.sv
// Directed bench for mbox_sender: one task per scenario, each self-checking.
module mbox_sender_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [7:0]   fetch_valid;
    logic [511:0] fetch_data;
    logic [7:0]   fetch_ack = '0;
    logic         irq;
    int           total = 0, bad = 0;

    always #2.5 clk = ~clk;

    mbox_sender u_mbox_sender (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fetch_valid(fetch_valid),
        .fetch_data(fetch_data), .fetch_ack(fetch_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic post(input int t, input logic [31:0] lo, input logic [31:0] hi);
        wr(8'h04, lo);
        wr(8'h08, hi);
        wr(8'h00, 32'(t));
        wr(8'h0C, 32'h1);
    endtask

    task automatic ack(input logic [7:0] v);
        @(negedge clk);
        fetch_ack = v;
        @(negedge clk);
        fetch_ack = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h14, d); check("R1 status", 64'(d), 64'h0);
        rd(8'h1C, d); check("R1 mask", 64'(d), 64'h7);
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 valid", 64'(fetch_valid), 64'h0);
    endtask

    task automatic t_post;
        logic [31:0] d;
        post(3, 32'hAAAA0001, 32'hBBBB0002);
        check("R2 valid", 64'(fetch_valid), 64'h08);
        check("R2 data", fetch_data[3*64 +: 64], 64'hBBBB0002_AAAA0001);
        rd(8'h14, d); check("R2 status", 64'(d), 64'h08);
        rd(8'h04, d); check("R9 low readback", 64'(d), 64'hAAAA0001);
        rd(8'h00, d); check("R9 target readback", 64'(d), 64'h3);
        wr(8'h00, 32'h5);
        wr(8'h0C, 32'h2);
        check("R2 trigger bit0 clear ignored", 64'(fetch_valid), 64'h08);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        post(3, 32'h11111111, 32'h22222222);
        rd(8'h14, d); check("R3 overflow flag", 64'(d), 64'h0808);
        check("R3 data kept", fetch_data[3*64 +: 64], 64'hBBBB0002_AAAA0001);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        ack(8'h08);
        rd(8'h14, d); check("R4 deliver", 64'(d), 64'h080800);
        check("R4 valid drop", 64'(fetch_valid), 64'h0);
        ack(8'h40);
        rd(8'h14, d); check("R4 idle ack ignored", 64'(d), 64'h080800);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(8'h10, 32'h000800);
        rd(8'h14, d); check("R5 clear overflow only", 64'(d), 64'h080000);
        post(1, 32'h1, 32'h2);
        wr(8'h10, 32'hFFFFFF);
        rd(8'h14, d); check("R5 busy kept", 64'(d), 64'h000002);
        ack(8'h02);
        rd(8'h14, d); check("R4 deliver t1", 64'(d), 64'h020000);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        check("R6 masked no irq", 64'(irq), 64'h0);
        wr(8'h1C, 32'h3);
        @(negedge clk);
        check("R6 deliver irq", 64'(irq), 64'h1);
        rd(8'h18, d); check("R6 pending read", 64'(d), 64'h1);
        wr(8'h10, 32'hFF0000);
        wr(8'h18, 32'h1);
        @(negedge clk);
        check("R7 clear pending", 64'(irq), 64'h0);
        wr(8'h1C, 32'h5);
        post(2, 32'h5, 32'h6);
        check("R6 busy masked", 64'(irq), 64'h0);
        post(2, 32'h7, 32'h8);
        @(negedge clk);
        check("R6 overflow irq", 64'(irq), 64'h1);
        wr(8'h10, 32'h00FF00);
        wr(8'h18, 32'h1);
        @(negedge clk);
        check("R7 clear after overflow", 64'(irq), 64'h0);
        wr(8'h1C, 32'h6);
        @(negedge clk);
        check("R6 busy irq", 64'(irq), 64'h1);
        wr(8'h18, 32'h1);
        @(negedge clk);
        check("R7 reassert while source held", 64'(irq), 64'h1);
        wr(8'h1C, 32'h7);
        ack(8'h04);
        wr(8'h10, 32'hFFFF00);
        wr(8'h18, 32'h1);
        @(negedge clk);
        check("R7 quiet", 64'(irq), 64'h0);
    endtask

    task automatic t_multi;
        logic [31:0] d;
        for (int t = 0; t < 8; t++) post(t, 32'h100 + 32'(t), 32'hC000 + 32'(t));
        check("R8 all valid", 64'(fetch_valid), 64'hFF);
        for (int t = 0; t < 8; t++)
            check("R8 slot data", fetch_data[t*64 +: 64], {32'hC000 + 32'(t), 32'h100 + 32'(t)});
        ack(8'hA5);
        rd(8'h14, d); check("R8 partial ack", 64'(d), 64'hA5005A);
        ack(8'hFF);
        rd(8'h14, d); check("R8 all delivered", 64'(d), 64'hFF0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_post();
        t_overflow();
        t_ack();
        t_clear();
        t_irq();
        t_multi();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule